// File: doc/BRIEF.md
# Lane-wise Masked Dword Shuffle Unit

This unit rearranges the 32-bit elements of a vector up to 512 bits wide. Each
128-bit lane is treated as a group of four elements. One 8-bit order control
says, for each destination slot of a lane, which of that lane's four source
elements lands there. The same order is used in every lane. Before the
shuffle, the lowest source element can be copied to every position. After the
shuffle, a per-element writemask decides which results are kept. Elements that
are masked off either keep the old destination value or become zero.

A length code sets how many elements are live. Bits above that length are
cleared. A legacy flag narrows the operation to the low 128 bits and passes the
old destination through above them. A reserved 4-bit field must read all ones.
Any other value marks the request illegal and produces no result.

Requests are taken on a one-cycle strobe. The result, with its valid flag or
its illegal flag, appears one clock later.

Top module: `lane_dword_permuter`

## Requirements
- R1: Within a lane, order bits [1:0] pick the source element for destination element 0, [3:2] for element 1, [5:4] for element 2 and [7:6] for element 3. A field value n selects lane element n.
- R2: Every 128-bit lane uses the same order byte and takes elements only from its own lane of the source.
- R3: One source element may be chosen by several fields. For example, order 8'h00 fills each lane with that lane's element 0.
- R4: The length code sets the live elements: 2'b00 gives 4 (128 bits), 2'b01 gives 8 (256 bits), and 2'b10 or 2'b11 gives 16 (512 bits). Outside legacy mode, every result bit above the live length is zero, and mask bits above the live length have no effect.
- R5: With masking enabled and broadcast set, source bits [31:0] are copied into every element position before the shuffle.
- R6: With masking enabled, live element j takes the shuffled value when mask bit j is 1. When mask bit j is 0, the element keeps the old destination value if zeroing is 0, and becomes zero if zeroing is 1.
- R7: In legacy mode, only the low 128 bits are live, and result bits 511:128 equal the old destination. The length code, mask, masking enable, zeroing and broadcast inputs have no effect.
- R8: With masking disabled, the mask, zeroing and broadcast inputs have no effect, and every live element takes its shuffled value.
- R9: If the reserved field is not 4'b1111 when a strobe arrives, the illegal flag is high on the next cycle, valid stays low, and the result keeps its previous value.
- R10: The result and valid appear exactly one cycle after an accepted strobe. A synchronous active-high reset clears valid, the illegal flag and the result.
- R11: In a cycle after no strobe, valid and the illegal flag are low and the result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src | input | 512 | Source vector |
| old_dst | input | 512 | Previous destination vector |
| order | input | 8 | Four 2-bit element selectors |
| vlen_sel | input | 2 | Length code |
| elem_mask | input | 16 | Per-element writemask |
| mask_en | input | 1 | Masking enable |
| zero_mode | input | 1 | 1 = zero masked elements, 0 = merge |
| bcast_en | input | 1 | Broadcast of element 0 |
| legacy | input | 1 | 128-bit mode that preserves the upper bits |
| resv | input | 4 | Reserved field, must be 4'b1111 |
| res | output | 512 | Registered result |
| res_valid | output | 1 | Result valid |
| illegal | output | 1 | Illegal encoding seen |

## Verification
The bench builds the unit with its default parameters: 32-bit elements, four elements per lane and four lanes. At these values all three lengths, the cross-lane boundaries and the full 16-bit mask can be exercised. Every source element carries its own index, so a pick from the wrong lane or the wrong slot shows up as a mismatch. The stimulus table combines merge, zero and legacy cases with repeated-index orders. Directed steps then cover back-to-back strobes, an idle cycle, illegal encodings and a reset in mid-run.

// File: rtl/dperm_pkg.sv
package dperm_pkg;

  localparam int unsigned RESV_W = 4;
  localparam logic [RESV_W-1:0] RESV_OK = '1;

  typedef enum logic [1:0] {
    VL_128 = 2'd0,
    VL_256 = 2'd1,
    VL_512 = 2'd2,
    VL_TOP = 2'd3
  } vlen_e;

  typedef struct packed {
    logic masked;
    logic zero;
    logic bcast;
    logic legacy;
  } ctl_t;

  // Number of live 128-bit lanes for a length code, clamped to the build size.
  function automatic int unsigned live_lanes(input logic [1:0] code,
                                             input logic       legacy,
                                             input int unsigned max_lanes);
    int unsigned n;
    if (legacy) return 1;
    n = 1 << code;
    if (n > max_lanes) n = max_lanes;
    return n;
  endfunction

  // Legacy and unmasked forms drop the mask-related controls.
  function automatic ctl_t decode_ctl(input logic mask_en, input logic zero_mode,
                                      input logic bcast_en, input logic legacy);
    ctl_t c;
    c.legacy = legacy;
    c.masked = mask_en & ~legacy;
    c.zero   = zero_mode & c.masked;
    c.bcast  = bcast_en & c.masked;
    return c;
  endfunction

endpackage

// File: rtl/dperm_bcast.sv
module dperm_bcast #(
  parameter int unsigned ELEM_W    = 32,
  parameter int unsigned NUM_ELEMS = 16
) (
  input  logic [ELEM_W*NUM_ELEMS-1:0] vec_in,
  input  logic                        en,
  output logic [ELEM_W*NUM_ELEMS-1:0] vec_out
);
  localparam int unsigned VEC_W = ELEM_W * NUM_ELEMS;

  logic [VEC_W-1:0] splat;

  generate
    for (genvar e = 0; e < NUM_ELEMS; e++) begin : g_splat
      assign splat[e*ELEM_W +: ELEM_W] = vec_in[ELEM_W-1:0];
    end
  endgenerate

  assign vec_out = en ? splat : vec_in;
endmodule

// File: rtl/dperm_lane.sv
module dperm_lane #(
  parameter int unsigned ELEM_W     = 32,
  parameter int unsigned LANE_ELEMS = 4,
  parameter int unsigned SEL_W      = $clog2(LANE_ELEMS),
  parameter int unsigned ORDER_W    = LANE_ELEMS * SEL_W
) (
  input  logic [ELEM_W*LANE_ELEMS-1:0] lane_in,
  input  logic [ORDER_W-1:0]           order,
  output logic [ELEM_W*LANE_ELEMS-1:0] lane_out
);
  localparam int unsigned LANE_W = ELEM_W * LANE_ELEMS;

  function automatic logic [ELEM_W-1:0] pick(input logic [LANE_W-1:0] v,
                                             input logic [SEL_W-1:0]  s);
    return v[s*ELEM_W +: ELEM_W];
  endfunction

  generate
    for (genvar k = 0; k < LANE_ELEMS; k++) begin : g_slot
      logic [SEL_W-1:0] slot_sel;
      assign slot_sel = order[k*SEL_W +: SEL_W];
      assign lane_out[k*ELEM_W +: ELEM_W] = pick(lane_in, slot_sel);
    end
  endgenerate
endmodule

// File: rtl/dperm_wmask.sv
module dperm_wmask #(
  parameter int unsigned ELEM_W    = 32,
  parameter int unsigned NUM_ELEMS = 16
) (
  input  logic [ELEM_W*NUM_ELEMS-1:0] shuf,
  input  logic [ELEM_W*NUM_ELEMS-1:0] old_dst,
  input  logic [NUM_ELEMS-1:0]        elem_mask,
  input  logic [NUM_ELEMS-1:0]        live,
  input  logic                        masked,
  input  logic                        zero,
  input  logic                        legacy,
  output logic [ELEM_W*NUM_ELEMS-1:0] merged
);
  function automatic logic [ELEM_W-1:0] settle(
      input logic [ELEM_W-1:0] s, input logic [ELEM_W-1:0] o,
      input logic lv, input logic mb, input logic msk,
      input logic zr, input logic lg);
    if (!lv)              return lg ? o : '0;
    if (!msk || mb)       return s;
    return zr ? '0 : o;
  endfunction

  generate
    for (genvar j = 0; j < NUM_ELEMS; j++) begin : g_elem
      assign merged[j*ELEM_W +: ELEM_W] =
        settle(shuf[j*ELEM_W +: ELEM_W], old_dst[j*ELEM_W +: ELEM_W],
               live[j], elem_mask[j], masked, zero, legacy);
    end
  endgenerate
endmodule

// File: rtl/lane_dword_permuter.sv
module lane_dword_permuter
  import dperm_pkg::*;
#(
  parameter int unsigned ELEM_W     = 32,
  parameter int unsigned LANE_ELEMS = 4,
  parameter int unsigned NUM_LANES  = 4,
  parameter int unsigned SEL_W      = $clog2(LANE_ELEMS),
  parameter int unsigned ORDER_W    = LANE_ELEMS * SEL_W,
  parameter int unsigned NUM_ELEMS  = LANE_ELEMS * NUM_LANES,
  parameter int unsigned VEC_W      = ELEM_W * NUM_ELEMS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [VEC_W-1:0]   src,
  input  logic [VEC_W-1:0]   old_dst,
  input  logic [ORDER_W-1:0] order,
  input  logic [1:0]         vlen_sel,
  input  logic [NUM_ELEMS-1:0] elem_mask,
  input  logic               mask_en,
  input  logic               zero_mode,
  input  logic               bcast_en,
  input  logic               legacy,
  input  logic [3:0]         resv,
  output logic [VEC_W-1:0]   res,
  output logic               res_valid,
  output logic               illegal
);
  localparam int unsigned LANE_W = ELEM_W * LANE_ELEMS;

  // Named internal events
  ctl_t                 ctl;
  logic                 resv_good;
  logic                 accept;
  logic                 reject;
  logic [31:0]          lanes_live;
  logic [NUM_ELEMS-1:0] live;
  logic [VEC_W-1:0]     pre_vec;
  logic [VEC_W-1:0]     shuf_vec;
  logic [VEC_W-1:0]     next_res;

  assign ctl        = decode_ctl(mask_en, zero_mode, bcast_en, legacy);
  assign resv_good  = (resv == RESV_OK);
  assign accept     = in_valid & resv_good;
  assign reject     = in_valid & ~resv_good;
  assign lanes_live = live_lanes(vlen_sel, legacy, NUM_LANES);

  generate
    for (genvar j = 0; j < NUM_ELEMS; j++) begin : g_live
      assign live[j] = (32'(j / LANE_ELEMS) < lanes_live);
    end
  endgenerate

  dperm_bcast #(.ELEM_W(ELEM_W), .NUM_ELEMS(NUM_ELEMS)) u_bcast (
    .vec_in (src),
    .en     (ctl.bcast),
    .vec_out(pre_vec)
  );

  generate
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      dperm_lane #(.ELEM_W(ELEM_W), .LANE_ELEMS(LANE_ELEMS),
                   .SEL_W(SEL_W), .ORDER_W(ORDER_W)) u_lane (
        .lane_in (pre_vec[l*LANE_W +: LANE_W]),
        .order   (order),
        .lane_out(shuf_vec[l*LANE_W +: LANE_W])
      );
    end
  endgenerate

  dperm_wmask #(.ELEM_W(ELEM_W), .NUM_ELEMS(NUM_ELEMS)) u_wmask (
    .shuf     (shuf_vec),
    .old_dst  (old_dst),
    .elem_mask(elem_mask),
    .live     (live),
    .masked   (ctl.masked),
    .zero     (ctl.zero),
    .legacy   (ctl.legacy),
    .merged   (next_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      illegal   <= 1'b0;
      res       <= '0;
    end else begin
      res_valid <= accept;
      illegal   <= reject;
      if (accept) res <= next_res;
    end
  end

  // Output flag guards
  assert_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && illegal));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $stable(res));

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(in_valid));

  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> (!res_valid && !illegal));

  generate
    if (NUM_LANES > 1) begin : g_upper_chk
      assert_legacy_upper_R7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(legacy)) |->
          res[VEC_W-1:LANE_W] == $past(old_dst[VEC_W-1:LANE_W]));

      assert_len_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !$past(legacy) && $past(vlen_sel) == VL_128) |->
          res[VEC_W-1:LANE_W] == '0);
    end
  endgenerate
endmodule

// File: tb/lane_dword_permuter_test.sv
module lane_dword_permuter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  typedef struct packed {
    logic [7:0]  order;
    logic [1:0]  vl;
    logic [15:0] mask;
    logic        men;
    logic        zm;
    logic        bc;
    logic        leg;
    logic [3:0]  resv;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{8'h1B, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF},
    '{8'hE4, 2'd2, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF},
    '{8'h1B, 2'd2, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF},
    '{8'h00, 2'd1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF},
    '{8'hB1, 2'd2, 16'hA5C3, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF},
    '{8'hB1, 2'd2, 16'hA5C3, 1'b1, 1'b1, 1'b0, 1'b0, 4'hF},
    '{8'h4E, 2'd1, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF},
    '{8'h4E, 2'd3, 16'h0F0F, 1'b1, 1'b1, 1'b1, 1'b0, 4'hF},
    '{8'h39, 2'd2, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF},
    '{8'h93, 2'd0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 4'hF},
    '{8'hD8, 2'd1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF},
    '{8'h27, 2'd0, 16'hFFF0, 1'b1, 1'b1, 1'b0, 1'b0, 4'hF},
    '{8'hE4, 2'd2, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 4'h7},
    '{8'h1B, 2'd1, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 4'hE}
  };

  localparam string TAG [NV] = '{
    "R1", "R1", "R2", "R3", "R6", "R6", "R5", "R4",
    "R7", "R8", "R8", "R4", "R9", "R9"
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [511:0] src, old_dst, res;
  logic [7:0]   order;
  logic [1:0]   vlen_sel;
  logic [15:0]  elem_mask;
  logic         mask_en, zero_mode, bcast_en, legacy;
  logic [3:0]   resv;
  logic         res_valid, illegal;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  lane_dword_permuter uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .old_dst(old_dst),
    .order(order), .vlen_sel(vlen_sel), .elem_mask(elem_mask),
    .mask_en(mask_en), .zero_mode(zero_mode), .bcast_en(bcast_en),
    .legacy(legacy), .resv(resv), .res(res), .res_valid(res_valid),
    .illegal(illegal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference: element-by-element walk, written from the requirements.
  function automatic logic [511:0] model(input logic [511:0] s, input logic [511:0] o,
                                         input vec_t v);
    logic [511:0] r;
    int n;
    logic use_mask, use_zero, use_bc;
    use_mask = v.men && !v.leg;
    use_zero = use_mask && v.zm;
    use_bc   = use_mask && v.bc;
    if (v.leg) n = 4;
    else if (v.vl == 2'd0) n = 4;
    else if (v.vl == 2'd1) n = 8;
    else n = 16;
    for (int e = 0; e < 16; e++) begin
      int ln, p, pick;
      logic [31:0] val;
      ln   = e / 4;
      p    = e % 4;
      pick = (v.order >> (2 * p)) & 3;
      val  = use_bc ? s[31:0] : s[(ln * 4 + pick) * 32 +: 32];
      if (e >= n)                       r[e*32 +: 32] = v.leg ? o[e*32 +: 32] : 32'h0;
      else if (!use_mask || v.mask[e])  r[e*32 +: 32] = val;
      else if (use_zero)                r[e*32 +: 32] = 32'h0;
      else                              r[e*32 +: 32] = o[e*32 +: 32];
    end
    return r;
  endfunction

  function automatic logic [511:0] mk_src(input int seed);
    logic [511:0] v;
    for (int e = 0; e < 16; e++) v[e*32 +: 32] = {8'h5A ^ 8'(seed), 8'(seed), 8'hE0, 8'(e)};
    return v;
  endfunction

  function automatic logic [511:0] mk_old(input int seed);
    logic [511:0] v;
    for (int e = 0; e < 16; e++) v[e*32 +: 32] = {8'hC3, 8'(seed), 8'h0D, 8'(e)};
    return v;
  endfunction

  task automatic chk_vec(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s res act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input int seed);
    src       = mk_src(seed);
    old_dst   = mk_old(seed);
    order     = v.order;
    vlen_sel  = v.vl;
    elem_mask = v.mask;
    mask_en   = v.men;
    zero_mode = v.zm;
    bcast_en  = v.bc;
    legacy    = v.leg;
    resv      = v.resv;
    in_valid  = 1'b1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog act=%0d exp=<100000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [511:0] last, e1, e2;
    rst = 1'b1; in_valid = 1'b0; src = '0; old_dst = '0; order = '0;
    vlen_sel = '0; elem_mask = '0; mask_en = 0; zero_mode = 0; bcast_en = 0;
    legacy = 0; resv = 4'hF;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk_bit("R10", "valid", res_valid, 1'b0);
    chk_bit("R10", "illegal", illegal, 1'b0);
    chk_vec("R10", res, '0);
    rst = 1'b0;
    @(negedge clk);
    last = '0;

    for (int i = 0; i < NV; i++) begin
      logic [511:0] exp;
      drive(TBL[i], i + 1);
      exp = model(src, old_dst, TBL[i]);
      @(negedge clk);
      in_valid = 1'b0;
      if (TBL[i].resv == 4'hF) begin
        chk_bit(TAG[i], "valid", res_valid, 1'b1);
        chk_bit(TAG[i], "illegal", illegal, 1'b0);
        chk_vec(TAG[i], res, exp);
        last = exp;
      end else begin
        chk_bit(TAG[i], "valid", res_valid, 1'b0);
        chk_bit(TAG[i], "illegal", illegal, 1'b1);
        chk_vec(TAG[i], res, last);
      end
    end

    // R11: idle cycle keeps the result
    @(negedge clk);
    chk_bit("R11", "valid", res_valid, 1'b0);
    chk_bit("R11", "illegal", illegal, 1'b0);
    chk_vec("R11", res, last);

    // R10: back-to-back strobes, one result per cycle
    drive(TBL[2], 40);
    e1 = model(src, old_dst, TBL[2]);
    @(negedge clk);
    chk_bit("R10", "valid", res_valid, 1'b1);
    chk_vec("R10", res, e1);
    drive(TBL[5], 41);
    e2 = model(src, old_dst, TBL[5]);
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit("R10", "valid", res_valid, 1'b1);
    chk_vec("R10", res, e2);

    // R7: legacy result ignores mask-related inputs and the length code
    drive(TBL[8], 50);
    vlen_sel = 2'd0; elem_mask = 16'hFFFF; zero_mode = 1'b0; bcast_en = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk_vec("R7", res, model(mk_src(50), mk_old(50), TBL[8]));

    // R10: reset mid-run clears outputs
    drive(TBL[1], 60);
    rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit("R10", "valid", res_valid, 1'b0);
    chk_vec("R10", res, '0);
    rst = 1'b0;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule